// File: doc/BRIEF.md
# Accelerometer SPI Register Access Engine

This block is a SPI master that performs one register access at a time on a 3-axis accelerometer with a 6-bit register address space. A command is a read/write flag, an address and a write byte. The block sends a one-byte header `{read, 0, addr[5:0]}`, MSB first. It then moves one data byte in SPI mode 3: SCLK idles high, MOSI changes on falling edges and MISO is sampled on rising edges. When chip select is released, the block reports the byte it received.

Two sources can issue commands, and the `sw_own` control picks which one owns the port.

- **Software** (`sw_own` = 1) writes a packed 32-bit command word with a one-cycle strobe. It reads back a packed status word that carries a done flag.
- **Hardware sequencer** (`sw_own` = 0) presents commands on a valid/ready stream. Back-pressure works as follows:
  - `hw_cmd_ready` is high only while the block owns no transaction and hardware owns the port.
  - A command is taken on a cycle where both valid and ready are high.
  - While ready is low, the source must hold `hw_cmd_valid` high and keep the payload stable.
  - The result comes back as a one-cycle `hw_rsp_valid` pulse. The response side has no ready signal, because the sequencer always accepts it.

The SCLK half period is a whole number of system clocks. It is derived from parameters so that SCLK never runs faster than `SCLK_MAX_HZ`. Chip select leads the first SCLK edge by one half period and trails the last edge by one half period. After chip select is released, a deselect gap of `GAP_HALVES` half periods must pass before the next command is accepted.

Top module: `accel_spi_access`

## Requirements
- R1: After reset, `status_word` is all zeros, `spi_cs_n` = 1 and `spi_sclk` = 1.
- R2: The command word and the status word share these field positions: bit 31 = read (1) / write (0), bits 29:24 = address, bits 23:16 = write byte. The status word echoes these fields of the last accepted command, from either source. All other status bits except 15 and 7:0 read 0.
- R3: A frame is 16 bits, MSB first: header `{rd, 1'b0, addr[5:0]}` and then the data byte. For a write, the data byte is the write byte. SCLK idles high, MOSI changes only on falling edges and stays stable across rising edges, and chip select rises only while SCLK is high.
- R4: Status bits 7:0 are cleared when a command is accepted. When a read completes, they hold the byte sampled from MISO during the second byte of the frame. After a write they stay 0.
- R5: With accept at clock edge E and H = HALF cycles:
  - `spi_cs_n` falls at E.
  - SCLK falling edges occur at E + H·(2k+1) and rising edges at E + H·(2k+2), for k = 0..15.
  - `spi_cs_n` rises at E + 33·H.
  - SCLK toggles only while `spi_cs_n` is low.
- R6: Status bit 15 (done) is cleared by an accepted command. It is set on the same clock edge on which `spi_cs_n` rises.
- R7: A software strobe is ignored while a transaction or its deselect gap is in progress, and also while `sw_own` = 0. An ignored strobe starts no frame and does not change the status word.
- R8: `hw_cmd_ready` = 1 exactly when `sw_own` = 0 and the engine is idle. The engine returns to idle at E + (33 + GAP_HALVES)·H. A held `hw_cmd_valid` is accepted on the first cycle that ready is high.
- R9: For a hardware-issued command, `hw_rsp_valid` pulses for one cycle, starting on the edge where `spi_cs_n` rises, with `hw_rsp_data` = the byte received.
- R10: HALF = ceil(CLK_HZ / (2·SCLK_MAX_HZ)). With the default values (100 MHz and 5 MHz), each SCLK low phase lasts 10 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_own | input | 1 | 1: software owns the port, 0: hardware sequencer owns it |
| sw_wr | input | 1 | One-cycle strobe that writes `sw_cmd_word` |
| sw_cmd_word | input | 32 | Packed software command |
| status_word | output | 32 | Packed echo of the command, done flag and read byte |
| hw_cmd_valid | input | 1 | Hardware command valid |
| hw_cmd_ready | output | 1 | Hardware command ready |
| hw_cmd_rd | input | 1 | Hardware command: 1 read, 0 write |
| hw_cmd_addr | input | 6 | Hardware command register address |
| hw_cmd_wdata | input | 8 | Hardware command write byte |
| hw_rsp_valid | output | 1 | One-cycle pulse when a hardware-issued access ends |
| hw_rsp_data | output | 8 | Byte received in that access |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data from the master |
| spi_miso | input | 1 | SPI data to the master |

## Verification
A wrong engine state or a bad half-period count shows at the ports within one half period. `spi_cs_n` or `spi_sclk` toggles on the wrong cycle, or `hw_cmd_ready` and the done bit change at the wrong edge. A behavioural cycle-count model in the bench catches this on the first clock where they differ. Shift-register or arbitration faults show up after a whole frame: a wrong header or data byte reaches the bench's SPI slave model, a wrong byte lands in status bits 7:0 or on `hw_rsp_data`, or a strobe that should have been ignored leaves an extra frame.

// File: rtl/accel_spi_pkg.sv
package accel_spi_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FRAME_W = 2 + ADDR_W + DATA_W;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } acc_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TAIL,
    ST_GAP
  } eng_state_t;

  function automatic int unsigned half_div_f(int unsigned clk_hz, int unsigned sclk_hz);
    return (clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
  endfunction
endpackage

// File: rtl/accel_spi_tick.sv
module accel_spi_tick #(
  parameter int unsigned HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_every
      assign tick = en;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == CW'(HALF - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == CW'(HALF - 1));
    end
  endgenerate
endmodule

// File: rtl/accel_spi_arb.sv
module accel_spi_arb
  import accel_spi_pkg::*;
(
  input  logic              sw_own,
  input  logic              idle,
  input  logic              sw_wr,
  input  logic [31:0]       sw_word,
  input  logic              hw_valid,
  input  logic              hw_rd,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_wdata,
  output logic              hw_ready,
  output logic              start,
  output logic              start_hw,
  output acc_cmd_t          start_cmd
);
  logic sw_acc;

  assign hw_ready = !sw_own && idle;
  assign sw_acc   = sw_own && idle && sw_wr;
  assign start_hw = hw_ready && hw_valid;
  assign start    = sw_acc || start_hw;

  always_comb begin
    if (sw_own) begin
      start_cmd.rd    = sw_word[31];
      start_cmd.addr  = sw_word[29:24];
      start_cmd.wdata = sw_word[23:16];
    end else begin
      start_cmd.rd    = hw_rd;
      start_cmd.addr  = hw_addr;
      start_cmd.wdata = hw_wdata;
    end
  end
endmodule

// File: rtl/accel_spi_engine.sv
module accel_spi_engine
  import accel_spi_pkg::*;
#(
  parameter int unsigned GAP_HALVES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  acc_cmd_t          cmd,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              finish,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned BIT_W = $clog2(FRAME_W);
  localparam int unsigned GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  eng_state_t         state;
  logic [FRAME_W-1:0] tx;
  logic [BIT_W-1:0]   bitcnt;
  logic [GAP_W-1:0]   gcnt;

  assign busy   = (state != ST_IDLE);
  assign finish = (state == ST_TAIL) && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      tx      <= '0;
      rx_byte <= '0;
      bitcnt  <= '0;
      gcnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_LEAD;
          cs_n   <= 1'b0;
          tx     <= {cmd.rd, 1'b0, cmd.addr, cmd.wdata};
          bitcnt <= '0;
          gcnt   <= '0;
        end
        ST_LEAD: if (tick) begin
          sclk  <= 1'b0;
          mosi  <= tx[FRAME_W-1];
          tx    <= {tx[FRAME_W-2:0], 1'b0};
          state <= ST_XFER;
        end
        ST_XFER: if (tick) begin
          if (sclk) begin
            sclk <= 1'b0;
            mosi <= tx[FRAME_W-1];
            tx   <= {tx[FRAME_W-2:0], 1'b0};
          end else begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[DATA_W-2:0], miso};
            if (bitcnt == BIT_W'(FRAME_W - 1)) state <= ST_TAIL;
            else bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_TAIL: if (tick) begin
          cs_n  <= 1'b1;
          state <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gcnt == GAP_W'(GAP_HALVES - 1)) state <= ST_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the clock moves only inside a selected frame
  assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> !cs_n);
  // R3: release happens with the clock parked high
  assert_release_sclk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sclk);
  // R3: MOSI holds across a sampling (rising) edge
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/accel_spi_access.sv
module accel_spi_access
  import accel_spi_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SCLK_MAX_HZ = 5_000_000,
  parameter int unsigned GAP_HALVES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_own,
  input  logic        sw_wr,
  input  logic [31:0] sw_cmd_word,
  output logic [31:0] status_word,
  input  logic        hw_cmd_valid,
  output logic        hw_cmd_ready,
  input  logic        hw_cmd_rd,
  input  logic [5:0]  hw_cmd_addr,
  input  logic [7:0]  hw_cmd_wdata,
  output logic        hw_rsp_valid,
  output logic [7:0]  hw_rsp_data,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int unsigned HALF = half_div_f(CLK_HZ, SCLK_MAX_HZ);

  logic              busy, tick, start, start_hw, finish;
  acc_cmd_t          start_cmd, cmd_q;
  logic [DATA_W-1:0] rx_byte, rdata_q;
  logic              done_q, src_hw_q;

  accel_spi_arb u_arb (
    .sw_own    (sw_own),
    .idle      (!busy),
    .sw_wr     (sw_wr),
    .sw_word   (sw_cmd_word),
    .hw_valid  (hw_cmd_valid),
    .hw_rd     (hw_cmd_rd),
    .hw_addr   (hw_cmd_addr),
    .hw_wdata  (hw_cmd_wdata),
    .hw_ready  (hw_cmd_ready),
    .start     (start),
    .start_hw  (start_hw),
    .start_cmd (start_cmd)
  );

  accel_spi_tick #(.HALF(HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy),
    .tick  (tick)
  );

  accel_spi_engine #(.GAP_HALVES(GAP_HALVES)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd     (start_cmd),
    .tick    (tick),
    .miso    (spi_miso),
    .busy    (busy),
    .finish  (finish),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .rx_byte (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q        <= '0;
      done_q       <= 1'b0;
      rdata_q      <= '0;
      src_hw_q     <= 1'b0;
      hw_rsp_valid <= 1'b0;
      hw_rsp_data  <= '0;
    end else begin
      hw_rsp_valid <= finish && src_hw_q;
      if (finish) hw_rsp_data <= rx_byte;
      if (start) begin
        cmd_q    <= start_cmd;
        done_q   <= 1'b0;
        rdata_q  <= '0;
        src_hw_q <= start_hw;
      end else if (finish) begin
        done_q <= 1'b1;
        if (cmd_q.rd) rdata_q <= rx_byte;
      end
    end
  end

  assign status_word = {cmd_q.rd, 1'b0, cmd_q.addr, cmd_q.wdata, done_q, 7'b0, rdata_q};

  // R6: done is up on the edge chip select is released
  assert_done_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done_q);
  // R6: an accepted command clears done
  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_q);
  // R7: a command is only taken while the port is released
  assert_start_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> spi_cs_n);
  // R7: the echoed command cannot change during a transaction
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  // R9: a response pulse coincides with the release edge
  assert_rsp_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rsp_valid |-> $rose(spi_cs_n));
endmodule

// File: tb/accel_spi_access_tb_top.sv
module accel_spi_access_tb_top;
  localparam int H = 10;   // ceil(100 MHz / (2 * 5 MHz))
  localparam int G = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_own = 1'b1, sw_wr = 1'b0;
  logic [31:0] sw_cmd_word = '0;
  logic [31:0] status_word;
  logic hw_cmd_valid = 1'b0, hw_cmd_ready, hw_cmd_rd = 1'b0;
  logic [5:0] hw_cmd_addr = '0;
  logic [7:0] hw_cmd_wdata = '0;
  logic hw_rsp_valid;
  logic [7:0] hw_rsp_data;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  accel_spi_access dut_i (
    .clk(clk), .rst_n(rst_n), .sw_own(sw_own), .sw_wr(sw_wr), .sw_cmd_word(sw_cmd_word),
    .status_word(status_word), .hw_cmd_valid(hw_cmd_valid), .hw_cmd_ready(hw_cmd_ready),
    .hw_cmd_rd(hw_cmd_rd), .hw_cmd_addr(hw_cmd_addr), .hw_cmd_wdata(hw_cmd_wdata),
    .hw_rsp_valid(hw_rsp_valid), .hw_rsp_data(hw_rsp_data), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // SPI slave model: 64 byte registers
  logic [7:0] mem [64];
  int scnt = 0, frames = 0;
  logic [15:0] shin = '0;
  logic [7:0] hdr = '0, last_hdr = '0;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = init_val(i);

  always @(negedge spi_cs_n) begin scnt = 0; shin = '0; end
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    shin = {shin[14:0], spi_mosi};
    scnt++;
    if (scnt == 8) hdr = shin[7:0];
  end
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0 && scnt >= 8 && scnt < 16 && hdr[7])
    spi_miso = mem[hdr[5:0]][15 - scnt];
  always @(posedge spi_cs_n) if (scnt == 16) begin
    frames++;
    last_hdr = hdr;
    if (!hdr[7]) mem[hdr[5:0]] = shin[7:0];
  end

  // Cycle-count reference model, compared on every clock
  int mt = -1;
  bit mdone = 0;
  int rsp_cnt = 0;
  logic [7:0] rsp_last = '0;
  int low_len = 0, last_low = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = -1; mdone = 0;
    end else if (mt >= 0) begin
      mt++;
      if (mt == 33 * H) mdone = 1;
      if (mt == (33 + G) * H) mt = -1;
    end else if ((sw_own && sw_wr) || (!sw_own && hw_cmd_valid)) begin
      mt = 0; mdone = 0;
    end
    #1;
    if (rst_n && !finished) begin
      int n;
      bit ecs, esclk;
      n = (mt >= 0) ? mt / H : -1;
      ecs = !(mt >= 0 && n < 33);
      esclk = !(mt >= 0 && n >= 1 && n <= 32 && (n % 2 == 1));
      chk(spi_cs_n == ecs, "R5 cs_n per cycle", spi_cs_n, ecs);
      chk(spi_sclk == esclk, "R5 sclk per cycle", spi_sclk, esclk);
      chk(status_word[15] == mdone, "R6 done per cycle", status_word[15], mdone);
      chk(hw_cmd_ready == (!sw_own && mt < 0), "R8 ready per cycle", hw_cmd_ready, !sw_own && mt < 0);
      if (hw_rsp_valid) begin rsp_cnt++; rsp_last = hw_rsp_data; end
      if (!spi_sclk) low_len++;
      else if (low_len != 0) begin last_low = low_len; low_len = 0; end
    end
  end

  task automatic sw_cmd(input bit rd, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    sw_cmd_word = {rd, 1'b0, a, d, 16'h0};
    sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic hw_cmd(input bit rd, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    hw_cmd_rd = rd; hw_cmd_addr = a; hw_cmd_wdata = d; hw_cmd_valid = 1'b1;
    while (!hw_cmd_ready) @(negedge clk);
    @(negedge clk);
    hw_cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mt != -1);
    @(negedge clk);
  endtask

  initial begin
    int f0, r0;
    logic [7:0] old;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_word == 32'h0, "R1 status after reset", status_word, 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b1, "R1 idle pins after reset", {spi_cs_n, spi_sclk}, 3);

    // software write
    sw_cmd(1'b0, 6'h2D, 8'h08);
    wait_idle();
    chk(mem[8'h2D] == 8'h08, "R3 write byte reached slave", mem[8'h2D], 8'h08);
    chk(last_hdr == 8'h2D, "R3 write header", last_hdr, 8'h2D);
    chk(status_word == 32'h2D08_8000, "R2 status echo of write", status_word, 32'h2D08_8000);
    chk(last_low == H, "R10 sclk low phase length", last_low, H);

    // software read back
    sw_cmd(1'b1, 6'h2D, 8'h00);
    wait_idle();
    chk(last_hdr == 8'hAD, "R3 read header", last_hdr, 8'hAD);
    chk(status_word[7:0] == 8'h08, "R4 read byte", status_word[7:0], 8'h08);
    chk(status_word[31:16] == 16'hAD00, "R2 status echo of read", status_word[31:16], 16'hAD00);

    // boundary addresses
    sw_cmd(1'b1, 6'h3F, 8'h00);
    wait_idle();
    chk(status_word[7:0] == init_val(63), "R4 read top address", status_word[7:0], init_val(63));
    sw_cmd(1'b0, 6'h00, 8'hFF);
    wait_idle();
    chk(mem[0] == 8'hFF, "R3 write address zero", mem[0], 8'hFF);
    chk(status_word[7:0] == 8'h00, "R4 rdata zero after write", status_word[7:0], 0);

    // strobe while busy is ignored
    f0 = frames; old = mem[8'h11];
    sw_cmd(1'b0, 6'h10, 8'h11);
    repeat (100) @(negedge clk);
    sw_cmd(1'b0, 6'h11, 8'h22);
    wait_idle();
    chk(frames - f0 == 1, "R7 one frame despite busy strobe", frames - f0, 1);
    chk(status_word[29:16] == 14'h1011, "R7 status keeps first command", status_word[29:16], 14'h1011);
    chk(mem[8'h11] == old, "R7 ignored target untouched", mem[8'h11], old);

    // strobe without ownership is ignored
    sw_own = 1'b0;
    f0 = frames;
    sw_cmd(1'b0, 6'h12, 8'h33);
    repeat (50) @(negedge clk);
    chk(frames == f0 && spi_cs_n, "R7 no frame without ownership", frames - f0, 0);
    chk(status_word[29:16] == 14'h1011, "R7 status unchanged without ownership", status_word[29:16], 14'h1011);

    // hardware read with response
    r0 = rsp_cnt;
    hw_cmd(1'b1, 6'h2D, 8'h00);
    wait_idle();
    chk(rsp_cnt - r0 == 1, "R9 one response pulse", rsp_cnt - r0, 1);
    chk(rsp_last == 8'h08, "R9 response byte", rsp_last, 8'h08);
    chk(status_word[31:24] == 8'hAD, "R2 status echoes hardware command", status_word[31:24], 8'hAD);

    // held hardware command waits for the gap
    f0 = frames;
    hw_cmd(1'b0, 6'h20, 8'hA5);
    hw_cmd(1'b0, 6'h21, 8'h5A);
    wait_idle();
    chk(frames - f0 == 2, "R8 held command completes", frames - f0, 2);
    chk(mem[8'h20] == 8'hA5 && mem[8'h21] == 8'h5A, "R8 both writes landed", {mem[8'h20], mem[8'h21]}, 16'hA55A);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule